// File: doc/BRIEF.md
# Soft-Ramp Stereo Attenuator

This block scales a stereo pair of signed samples by an attenuation held in units of 1/8 dB. A new level can come from the attenuation code or from the mute bit. The block does not jump to a new level unless told to. With soft ramp enabled, it walks the present level one code per frame strobe toward the requested value. The frame strobe is a one-cycle pulse taken from the left/right clock, once per stereo frame.

A rate of one code per frame gives 1 dB every eight frames. Mute is a ramp toward the largest attenuation code. Once that code is reached, the samples are forced to zero. With soft ramp off, the level lands on the request at the next frame strobe.

The gain is split into a whole number of 6 dB octaves and a remainder. The octaves become arithmetic right shifts. The remainder selects one of 48 fractional gain entries. Both samples are multiplied by that entry and then shifted.

Top module: `soft_ramp_atten`

## Requirements
- R1: While rst_n is low, level_o is 0 and left_o and right_o are 0.
- R2: With ramp_en_i high, each frame strobe moves level_o by exactly one code toward the target, up or down, and leaves it unchanged once it is equal.
- R3: level_o, left_o and right_o do not change in a cycle without a frame strobe.
- R4: With ramp_en_i low, level_o equals the target after the next frame strobe.
- R5: The target is the largest code (2**LVL_W-1, 255 by default) when mute_i is high, and atten_i otherwise. If the target changes during a ramp, the ramp goes on from the present level toward the new target.
- R6: busy_o is high exactly when level_o differs from the target.
- R7: On a frame strobe each output is loaded with (x*G[L mod 48]) >>> 15 >>> (L div 48). Here x is the signed input sample and L is level_o before that strobe. G[0]=32768 and G[n]=floor(G[n-1]*64596/65536).
- R8: On a frame strobe taken with mute_i high and level_o at the largest code, both outputs are loaded with 0. Without mute_i, the same code still passes a scaled nonzero sample.
- R9: After mute_i is released, the level ramps back down toward atten_i one code per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_i | input | 1 | One-cycle strobe per stereo frame |
| ramp_en_i | input | 1 | Soft ramp enable |
| mute_i | input | 1 | Mute request |
| atten_i | input | LVL_W | Requested attenuation in 1/8 dB codes |
| left_i | input | DATA_W | Left sample, signed |
| right_i | input | DATA_W | Right sample, signed |
| level_o | output | LVL_W | Present attenuation code |
| busy_o | output | 1 | Level differs from target |
| left_o | output | DATA_W | Scaled left sample |
| right_o | output | DATA_W | Scaled right sample |

## Verification
Jumps with the ramp off are separated from one-code steps with it on. Ramps are run both upward and downward, and one ramp is retargeted halfway, which tells a correct continuation from a restart. Long stretches without a strobe, with the target changing, show that the level moves only on frames. Pseudo-random signed samples at levels across several octaves test the fraction entry and the shift count. Mute and a bare maximum code are compared, so that zero forcing is told apart from heavy attenuation.

// File: rtl/sra_pkg.sv
package sra_pkg;
    localparam int OCT_STEPS = 48;      // codes per 6 dB octave
    localparam int GAIN_W    = 16;      // unsigned Q1.15
    localparam int STEP_MUL  = 64596;   // 2^(-1/48) in Q0.16

    typedef enum logic [1:0] {DIR_HOLD, DIR_UP, DIR_DOWN} dir_e;

    function automatic logic [GAIN_W-1:0] gain_entry(input int idx);
        longint g;
        g = 64'd32768;
        for (int i = 0; i < idx; i++) g = (g * STEP_MUL) >> 16;
        return g[GAIN_W-1:0];
    endfunction
endpackage

// File: rtl/sra_level_seq.sv
module sra_level_seq #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_i,
    input  logic             ramp_en_i,
    input  logic [LVL_W-1:0] target_i,
    output logic [LVL_W-1:0] level_o,
    output logic             busy_o
);
    import sra_pkg::*;

    typedef struct packed {
        logic [LVL_W-1:0] level;
    } seq_t;

    seq_t st_d, st_q;
    dir_e dir;

    always_comb begin
        st_d = st_q;
        if (st_q.level < target_i)      dir = DIR_UP;
        else if (st_q.level > target_i) dir = DIR_DOWN;
        else                            dir = DIR_HOLD;
        if (frame_i) begin
            if (!ramp_en_i) st_d.level = target_i;
            else begin
                case (dir)
                    DIR_UP:   st_d.level = st_q.level + 1'b1;
                    DIR_DOWN: st_d.level = st_q.level - 1'b1;
                    default:  st_d.level = st_q.level;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
    assign busy_o  = (dir != DIR_HOLD);

    a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && ramp_en_i && (level_o < target_i) |=> level_o == $past(level_o) + 1'b1);
    a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && ramp_en_i && (level_o > target_i) |=> level_o == $past(level_o) - 1'b1);
    a_r3_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> $stable(level_o));
    a_r4_jump: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && !ramp_en_i |=> level_o == $past(target_i));
endmodule

// File: rtl/sra_gain_lut.sv
module sra_gain_lut #(
    parameter int LVL_W = 8
) (
    input  logic [LVL_W-1:0]          level_i,
    output logic [sra_pkg::GAIN_W-1:0] gain_o,
    output logic [LVL_W-1:0]          shift_o
);
    import sra_pkg::*;
    localparam int IDX_W = $clog2(OCT_STEPS);

    logic [GAIN_W-1:0] tbl [OCT_STEPS];
    logic [IDX_W-1:0]  frac;

    for (genvar g = 0; g < OCT_STEPS; g++) begin : g_tbl
        assign tbl[g] = gain_entry(g);
    end

    always_comb begin
        shift_o = LVL_W'(int'(level_i) / OCT_STEPS);
        frac    = IDX_W'(int'(level_i) % OCT_STEPS);
        gain_o  = tbl[frac];
    end
endmodule

// File: rtl/sra_scaler.sv
module sra_scaler #(
    parameter int DATA_W = 24,
    parameter int LVL_W  = 8
) (
    input  logic signed [DATA_W-1:0]    sample_i,
    input  logic [sra_pkg::GAIN_W-1:0]  gain_i,
    input  logic [LVL_W-1:0]            shift_i,
    output logic signed [DATA_W-1:0]    sample_o
);
    import sra_pkg::*;
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam int FRAC   = GAIN_W - 1;

    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod     = PROD_W'(sample_i) * PROD_W'($signed({1'b0, gain_i}));
        sample_o = DATA_W'(prod >>> (FRAC + int'(shift_i)));
    end
endmodule

// File: rtl/soft_ramp_atten.sv
module soft_ramp_atten #(
    parameter int DATA_W = 24,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_i,
    input  logic              ramp_en_i,
    input  logic              mute_i,
    input  logic [LVL_W-1:0]  atten_i,
    input  logic [DATA_W-1:0] left_i,
    input  logic [DATA_W-1:0] right_i,
    output logic [LVL_W-1:0]  level_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] left_o,
    output logic [DATA_W-1:0] right_o
);
    import sra_pkg::*;
    localparam int NCH = 2;
    localparam logic [LVL_W-1:0] MAX_CODE = {LVL_W{1'b1}};

    typedef struct packed {
        logic [NCH-1:0][DATA_W-1:0] smp;
    } out_t;

    out_t out_d, out_q;
    logic [LVL_W-1:0]           target;
    logic [GAIN_W-1:0]          gain;
    logic [LVL_W-1:0]           shift;
    logic [NCH-1:0][DATA_W-1:0] din, scaled;

    assign target = mute_i ? MAX_CODE : atten_i;
    assign din[0] = left_i;
    assign din[1] = right_i;

    sra_level_seq #(.LVL_W(LVL_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .ramp_en_i(ramp_en_i),
        .target_i(target), .level_o(level_o), .busy_o(busy_o)
    );

    sra_gain_lut #(.LVL_W(LVL_W)) u_lut (
        .level_i(level_o), .gain_o(gain), .shift_o(shift)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        sra_scaler #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_scl (
            .sample_i(din[c]), .gain_i(gain), .shift_i(shift), .sample_o(scaled[c])
        );
    end

    always_comb begin
        out_d = out_q;
        if (frame_i) begin
            if (mute_i && level_o == MAX_CODE) out_d.smp = '0;
            else                               out_d.smp = scaled;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign left_o  = out_q.smp[0];
    assign right_o = out_q.smp[1];

    a_r3_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> $stable(left_o) && $stable(right_o));
    a_r8_mute_zero: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && mute_i && level_o == MAX_CODE |=> left_o == '0 && right_o == '0);
    a_r6_busy_settled: assert property (@(posedge clk) disable iff (!rst_n)
        frame_i && !ramp_en_i && $stable(target) |=> !busy_o);
endmodule

// File: tb/soft_ramp_atten_test.sv
module soft_ramp_atten_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 24;
    localparam int LW = 8;
    localparam int MAXC = 255;

    logic clk = 0, rst_n = 0, frame = 0, ramp_en = 0, mute = 0;
    logic [LW-1:0] atten = 0;
    logic [DW-1:0] left = 0, right = 0;
    logic [LW-1:0] level;
    logic busy;
    logic [DW-1:0] lo, ro;

    int nchk = 0, nerr = 0;
    string tag = "R1";
    longint gtab [48];
    int m_level = 0;
    longint m_l = 0, m_r = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #(CLK_PERIOD/2) clk = ~clk;

    soft_ramp_atten #(.DATA_W(DW), .LVL_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .frame_i(frame), .ramp_en_i(ramp_en), .mute_i(mute),
        .atten_i(atten), .left_i(left), .right_i(right), .level_o(level), .busy_o(busy),
        .left_o(lo), .right_o(ro)
    );

    function automatic int tgt();
        return mute ? MAXC : int'(atten);
    endfunction

    function automatic longint scale(input logic [DW-1:0] x, input int lv);
        longint s;
        s = longint'($signed(x));
        return ((s * gtab[lv % 48]) >>> 15) >>> (lv / 48);
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_level = 0; m_l = 0; m_r = 0;
        end else if (frame) begin
            if (mute && m_level == MAXC) begin
                m_l = 0; m_r = 0;
            end else begin
                m_l = scale(left, m_level); m_r = scale(right, m_level);
            end
            if (!ramp_en)                m_level = tgt();
            else if (m_level < tgt())    m_level = m_level + 1;
            else if (m_level > tgt())    m_level = m_level - 1;
        end
    end

    task automatic compare();
        bit bad = 0;
        nchk++;
        if (int'(level) != m_level) begin
            bad = 1; $display("FAIL %s level: got %0d exp %0d", tag, level, m_level);
        end
        if (busy !== (m_level != tgt())) begin
            bad = 1; $display("FAIL %s R6 busy: got %0b exp %0b", tag, busy, m_level != tgt());
        end
        if (longint'($signed(lo)) != m_l) begin
            bad = 1; $display("FAIL %s R7 left: got %0d exp %0d", tag, $signed(lo), m_l);
        end
        if (longint'($signed(ro)) != m_r) begin
            bad = 1; $display("FAIL %s R7 right: got %0d exp %0d", tag, $signed(ro), m_r);
        end
        if (bad) nerr++;
    endtask

    task automatic expect_eq(input string t, input longint got, input longint exp);
        nchk++;
        if (got != exp) begin
            nerr++; $display("FAIL %s: got %0d exp %0d", t, got, exp);
        end
    endtask

    task automatic cyc(input bit fr);
        frame = fr;
        @(negedge clk);
        compare();
    endtask

    task automatic frames(input int n);
        for (int i = 0; i < n; i++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            left = seed[30:7];
            seed = seed * 32'd1103515245 + 32'd12345;
            right = seed[30:7];
            cyc(1); cyc(0); cyc(0); cyc(0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nerr++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        gtab[0] = 32768;
        for (int i = 1; i < 48; i++) gtab[i] = (gtab[i-1] * 64596) >>> 16;

        @(negedge clk);
        tag = "R1";
        left = 24'h3f0000; right = 24'hc00000; frame = 1;
        for (int i = 0; i < 3; i++) @(negedge clk);
        expect_eq("R1 reset level", level, 0);
        expect_eq("R1 reset left", lo, 0);
        expect_eq("R1 reset right", ro, 0);
        frame = 0; rst_n = 1;
        cyc(0);

        tag = "R4"; ramp_en = 0; atten = 20;
        frames(1);
        expect_eq("R4 jump level", level, 20);
        frames(3);

        tag = "R2"; ramp_en = 1; atten = 60;
        frames(5);
        expect_eq("R2 five steps", level, 25);
        expect_eq("R6 busy mid ramp", busy, 1);
        frames(35);
        expect_eq("R2 ramp end", level, 60);
        expect_eq("R6 busy settled", busy, 0);

        tag = "R3"; atten = 100;
        for (int i = 0; i < 20; i++) begin
            atten = LW'(100 + i); cyc(0);
        end
        expect_eq("R3 no strobe hold", level, 60);

        tag = "R5"; atten = 100;
        frames(10);
        expect_eq("R5 up to 70", level, 70);
        atten = 65;
        frames(3);
        expect_eq("R5 retarget down", level, 67);
        frames(4);
        expect_eq("R5 settle 65", level, 65);

        tag = "R8"; mute = 1;
        frames(200);
        expect_eq("R8 mute level max", level, MAXC);
        frames(2);
        expect_eq("R8 muted left", lo, 0);
        expect_eq("R8 muted right", ro, 0);

        tag = "R9"; mute = 0; atten = 0;
        frames(10);
        expect_eq("R9 release ramps down", level, MAXC - 10);
        ramp_en = 0;
        frames(1);
        expect_eq("R9 jump to zero", level, 0);

        tag = "R8"; atten = LW'(MAXC);
        frames(1);
        left = 24'h400000; right = 24'hc00000;
        frame = 1; cyc(1); frame = 0; cyc(0);
        nchk++;
        if (lo == 0 || ro == 0) begin
            nerr++;
            $display("FAIL R8 unmuted max code: got %0d/%0d exp %0d/%0d", $signed(lo), $signed(ro),
                     scale(24'h400000, MAXC), scale(24'hc00000, MAXC));
        end

        tag = "R7"; ramp_en = 1; atten = 130;
        frames(40);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule